// File: doc/BRIEF.md
# Paged MDIO Bridge to a 32-bit Register Bus

This block sits on a management serial bus as a responder and opens a 32-bit register space that is far wider than a plain Clause 22 frame can address. The two upper bits of the 5-bit PHY-address field pick a mode. A page mode stores the upper address bits. A register mode carries the remaining word address and a half-word selector in the rest of the PHY-address and register-address fields.

Each 32-bit register is reached as two 16-bit halves. A write sends the upper half first, and the bridge holds it. The lower half then commits both halves in a single write strobe. A read starts with the lower half, which triggers one 32-bit bus read and keeps the upper 16 bits for the upper-half read that follows. The bridge oversamples the serial clock with its own system clock and answers reads on the falling serial-clock edge.

Top module: `mdio_paged_bridge`

## Requirements
- R1: After reset the bridge does not drive the line, issues no strobes, holds no pending upper half and no captured upper half, and the page value is 0.
- R2: Frames whose PHY-address bits [4:3] are 2'b01 or 2'b00 cause no bus access and no drive of the line. 2'b11 is page mode and 2'b10 is register mode.
- R3: A page-mode write (op 2'b01) stores data bits [9:0] as the page, which becomes bus address bits [18:9].
- R4: In register mode the bus address is {page, PHY-address[2:0], register-address[4:1], 2'b00}. Register-address bit 0 (address bit 1) selects the upper half when set.
- R5: An upper-half write stores its 16 bits and its word address and issues no strobe.
- R6: A lower-half write to the same word address as the held upper half issues exactly one write strobe with data {held upper, lower}. It then clears the hold, so a repeated lower-half write issues no strobe.
- R7: A lower-half write with no held upper half for that word issues no strobe, and it leaves an existing hold intact.
- R8: A lower-half read (op 2'b10) issues one read strobe and returns read-data bits [15:0] MSB first. It also keeps bits [31:16] for that word.
- R9: An upper-half read of the kept word returns the kept bits without a new strobe, and then drops them.
- R10: An upper-half read with nothing kept for that word issues a fresh read strobe and returns read-data bits [31:16].
- R11: On an answered read the line is undriven during the first turnaround bit and driven 0 during the second. It is released after the last data bit.
- R12: A page-mode read is not answered and causes no bus access.
- R13: Reset clears the page, so register addresses after reset use page 0 until a new page write arrives.
- R14: Write and read strobes are single system-clock pulses and never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset (switch reset) |
| mdc | input | 1 | Serial management clock |
| mdio_in | input | 1 | Serial data as seen on the line |
| mdio_out | output | 1 | Serial data driven by the bridge |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| reg_addr | output | PAGE_W+9 | Byte address of the 32-bit register, bits [1:0] zero |
| reg_wdata | output | 32 | Assembled write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Read data, sampled in the cycle reg_re is high |

## Verification
Serial inputs pass two synchronizer flops and an edge register, so each result appears three to four system clocks after the serial edge that causes it. A read strobe follows the rising edge of the 14th frame bit. A write strobe follows the rising edge of the 32nd bit. Driven read bits change shortly after each falling edge. The bench holds each serial-clock phase for eight system clocks and samples the line just before it raises the serial clock, which is where a master would sample. It counts strobes from a monitor over the whole frame and compares the counts only after the trailing idle bits, when every result of the frame is due.

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge #(
  parameter int PAGE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mdc,
  input  logic                mdio_in,
  output logic                mdio_out,
  output logic                mdio_oe,
  output logic [PAGE_W+8:0]   reg_addr,
  output logic [31:0]         reg_wdata,
  output logic                reg_we,
  output logic                reg_re,
  input  logic [31:0]         reg_rdata
);
  localparam int WW = PAGE_W + 7;
  localparam logic [1:0] MODE_PAGE = 2'd3;
  localparam logic [1:0] MODE_REG  = 2'd2;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  logic [2:0]        mdc_p;
  logic [1:0]        dio_p;
  logic              busy, fr_ok, fr_rd, drive, cur_h;
  logic [5:0]        cnt;
  logic [13:0]       hdr;
  logic [15:0]       wsh, resp, hold, cap;
  logic [1:0]        mode;
  logic [PAGE_W-1:0] page;
  logic [WW-1:0]     cur_w, hold_w, cap_w;
  logic              hold_v, cap_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mdc_p <= '0;
      dio_p <= '1;
    end else begin
      mdc_p <= {mdc_p[1:0], mdc};
      dio_p <= {dio_p[0], mdio_in};
    end

  wire rise = mdc_p[1] & ~mdc_p[2];
  wire fall = ~mdc_p[1] & mdc_p[2];
  wire din  = dio_p[1];

  wire [13:0]   hdr_n  = {hdr[12:0], din};
  wire [1:0]    f_st   = hdr_n[13:12];
  wire [1:0]    f_op   = hdr_n[11:10];
  wire [4:0]    f_phy  = hdr_n[9:5];
  wire [4:0]    f_reg  = hdr_n[4:0];
  wire          f_ok   = (f_st == 2'b01) && (f_op == OP_RD || f_op == OP_WR);
  wire [WW-1:0] f_word = {page, f_phy[2:0], f_reg[4:1]};
  wire          f_ans  = f_ok && (f_op == OP_RD) && (f_phy[4:3] == MODE_REG);
  wire          f_hit  = f_reg[0] && cap_v && (cap_w == f_word);
  wire [15:0]   wd_n   = {wsh[14:0], din};
  wire [5:0]    bsel   = 6'd31 - cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; hdr <= '0; wsh <= '0;
      fr_ok <= 1'b0; fr_rd <= 1'b0; drive <= 1'b0; cur_h <= 1'b0;
      mode <= '0; cur_w <= '0; page <= '0;
      resp <= '0; hold <= '0; hold_w <= '0; hold_v <= 1'b0;
      cap <= '0; cap_w <= '0; cap_v <= 1'b0;
      reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0; reg_re <= 1'b0;
      mdio_out <= 1'b0; mdio_oe <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_re) begin
        if (!cur_h) begin
          resp  <= reg_rdata[15:0];
          cap   <= reg_rdata[31:16];
          cap_w <= cur_w;
          cap_v <= 1'b1;
        end else begin
          resp  <= reg_rdata[31:16];
          cap_v <= 1'b0;
        end
      end
      if (rise) begin
        wsh <= wd_n;
        if (!busy) begin
          if (!din) begin
            busy <= 1'b1;
            cnt  <= 6'd1;
            hdr  <= '0;
          end
        end else if (cnt != 6'd32) begin
          hdr <= hdr_n;
          cnt <= cnt + 6'd1;
          if (cnt == 6'd13) begin
            fr_ok <= f_ok;
            fr_rd <= (f_op == OP_RD);
            mode  <= f_phy[4:3];
            cur_w <= f_word;
            cur_h <= f_reg[0];
            drive <= f_ans;
            if (f_ans) begin
              if (f_hit) begin
                resp  <= cap;
                cap_v <= 1'b0;
              end else begin
                reg_re   <= 1'b1;
                reg_addr <= {f_word, 2'b00};
              end
            end
          end
          if (cnt == 6'd31 && fr_ok && !fr_rd) begin
            if (mode == MODE_PAGE)
              page <= wd_n[PAGE_W-1:0];
            else if (mode == MODE_REG) begin
              if (cur_h) begin
                hold   <= wd_n;
                hold_w <= cur_w;
                hold_v <= 1'b1;
              end else if (hold_v && hold_w == cur_w) begin
                reg_we    <= 1'b1;
                reg_addr  <= {cur_w, 2'b00};
                reg_wdata <= {hold, wd_n};
                hold_v    <= 1'b0;
              end
            end
          end
        end
      end
      if (fall && busy) begin
        if (cnt == 6'd32) begin
          busy    <= 1'b0;
          drive   <= 1'b0;
          mdio_oe <= 1'b0;
        end else if (drive && cnt == 6'd15) begin
          mdio_oe  <= 1'b1;
          mdio_out <= 1'b0;
        end else if (drive && cnt >= 6'd16) begin
          mdio_out <= resp[bsel[3:0]];
        end
      end
    end
endmodule

module mdio_paged_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic reg_re,
  input logic mdio_oe,
  input logic mdio_out
);
  AST_WE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we);        // R14
  AST_RE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re);        // R14
  AST_NO_OVERLAP:   assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re));       // R14
  AST_TA_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) $rose(mdio_oe) |-> !mdio_out); // R11
  AST_WE_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> !mdio_oe);       // R6
  AST_RE_BEFORE_TA: assert property (@(posedge clk) disable iff (!rst_n) reg_re |-> !mdio_oe);       // R8
endmodule

bind mdio_paged_bridge mdio_paged_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
  .mdio_oe(mdio_oe), .mdio_out(mdio_out)
);

// File: tb/mdio_paged_bridge_bench.sv
`timescale 1ns/1ps
module mdio_paged_bridge_bench;
  logic clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mast = 1'b1;
  logic mdio_out, mdio_oe, reg_we, reg_re;
  logic [18:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  wire line = mdio_oe ? mdio_out : mast;

  always #2.5 clk = ~clk;

  assign reg_rdata = {~reg_addr[18:3], reg_addr[18:3]};

  mdio_paged_bridge u_mdio_paged_bridge (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  int checks = 0, fails = 0, we_n = 0, re_n = 0, oe_n = 0;
  logic [18:0] we_a, re_a;
  logic [31:0] we_d;
  bit done = 0;

  always @(negedge clk) begin
    if (reg_we) begin we_n++; we_a = reg_addr; we_d = reg_wdata; end
    if (reg_re) begin re_n++; re_a = reg_addr; end
    if (mdio_oe) oe_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic v, output logic s, output logic so);
    @(negedge clk);
    mdc = 1'b0;
    mast = v;
    repeat (8) @(negedge clk);
    s = line;
    so = mdio_oe;
    mdc = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, output logic [15:0] rv, output logic ta_ok,
                           output logic end_oe, output int d_we, output int d_re, output int d_oe);
    int we0, re0, oe0;
    logic [31:0] fr;
    logic s, so, t14, t15;
    we0 = we_n; re0 = re_n; oe0 = oe_n;
    t14 = 1'b0; t15 = 1'b0; rv = '0;
    fr = {2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, s, so);
    for (int i = 0; i < 32; i++) begin
      bit_cycle((rd && i >= 14) ? 1'b1 : fr[31-i], s, so);
      if (i == 14) t14 = !so;
      if (i == 15) t15 = so && !s;
      if (i >= 16) rv[31-i] = s;
    end
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, s, so);
    ta_ok = t14 && t15;
    end_oe = mdio_oe;
    d_we = we_n - we0; d_re = re_n - re0; d_oe = oe_n - oe0;
  endtask

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [15:0] ehi;
    logic [1:0]  nwe;
    logic [1:0]  nre;
    logic        drv;
    logic [18:0] eaddr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'h18, 5'h00, 16'h0005, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R3 page=5
    '{1'b0, 5'h13, 5'h05, 16'h1234, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R5
    '{1'b0, 5'h13, 5'h04, 16'h5678, 16'h5678, 16'h1234, 2'd1, 2'd0, 1'b0, 19'h0AC8},  // R6 R4
    '{1'b0, 5'h13, 5'h04, 16'h9999, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R6 hold gone
    '{1'b1, 5'h13, 5'h04, 16'h0000, 16'h0159, 16'h0000, 2'd0, 2'd1, 1'b1, 19'h0AC8},  // R8
    '{1'b1, 5'h13, 5'h05, 16'h0000, 16'hFEA6, 16'h0000, 2'd0, 2'd0, 1'b1, 19'h0},     // R9
    '{1'b1, 5'h13, 5'h05, 16'h0000, 16'hFEA6, 16'h0000, 2'd0, 2'd1, 1'b1, 19'h0AC8},  // R10
    '{1'b0, 5'h0B, 5'h04, 16'h1111, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R2 mode 1
    '{1'b1, 5'h03, 5'h04, 16'h0000, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R2 mode 0
    '{1'b1, 5'h18, 5'h00, 16'h0000, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R12
    '{1'b0, 5'h10, 5'h01, 16'hAAAA, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R5
    '{1'b0, 5'h11, 5'h00, 16'hCCCC, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R7 other word
    '{1'b0, 5'h10, 5'h00, 16'hBBBB, 16'hBBBB, 16'hAAAA, 2'd1, 2'd0, 1'b0, 19'h0A00},  // R7 hold kept, R6
    '{1'b0, 5'h18, 5'h00, 16'hFFFF, 16'h0000, 16'h0000, 2'd0, 2'd0, 1'b0, 19'h0},     // R3 page=3FF
    '{1'b1, 5'h17, 5'h1E, 16'h0000, 16'hFFFF, 16'h0000, 2'd0, 2'd1, 1'b1, 19'h7FFFC}  // R3 R4
  };

  initial begin
    logic [15:0] rv;
    logic ta_ok, end_oe;
    int dwe, dre, doe;
    repeat (5) @(negedge clk);
    chk(!mdio_oe && !reg_we && !reg_re, "R1", "idle outputs in reset", {29'b0, mdio_oe, reg_we, reg_re}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mdio_oe && !reg_we && !reg_re, "R1", "idle outputs after reset", {29'b0, mdio_oe, reg_we, reg_re}, 32'h0);
    run_frame(1'b0, 5'h10, 5'h00, 16'h4321, rv, ta_ok, end_oe, dwe, dre, doe);
    chk(dwe == 0, "R1", "no held upper half after reset", dwe, 0);
    run_frame(1'b1, 5'h10, 5'h02, 16'h0, rv, ta_ok, end_oe, dwe, dre, doe);
    chk(dre == 1 && re_a == 19'h4, "R1", "page 0 after reset", re_a, 19'h4);

    for (int k = 0; k < NV; k++) begin
      run_frame(TBL[k].rd, TBL[k].phy, TBL[k].rg, TBL[k].wd, rv, ta_ok, end_oe, dwe, dre, doe);
      chk(dwe == TBL[k].nwe, $sformatf("vec%0d", k), "write strobes", dwe, TBL[k].nwe);
      chk(dre == TBL[k].nre, $sformatf("vec%0d", k), "read strobes", dre, TBL[k].nre);
      chk((doe != 0) == TBL[k].drv, $sformatf("vec%0d R2/R12", k), "line driven", doe, TBL[k].drv);
      if (TBL[k].nwe != 0) begin
        chk(we_a == TBL[k].eaddr, $sformatf("vec%0d R4", k), "write address", we_a, TBL[k].eaddr);
        chk(we_d == {TBL[k].ehi, TBL[k].exp}, $sformatf("vec%0d R6", k), "write data", we_d, {TBL[k].ehi, TBL[k].exp});
      end
      if (TBL[k].nre != 0)
        chk(re_a == TBL[k].eaddr, $sformatf("vec%0d R4", k), "read address", re_a, TBL[k].eaddr);
      if (TBL[k].drv) begin
        chk(rv == TBL[k].exp, $sformatf("vec%0d R8/R9/R10", k), "read data", rv, TBL[k].exp);
        chk(ta_ok && !end_oe, $sformatf("vec%0d R11", k), "turnaround and release", {ta_ok, end_oe}, 2'b10);
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(1'b1, 5'h10, 5'h03, 16'h0, rv, ta_ok, end_oe, dwe, dre, doe);
    chk(dre == 1 && rv == 16'hFFFF, "R10", "upper read after reset refetches", {dre[15:0], rv}, {16'd1, 16'hFFFF});
    run_frame(1'b1, 5'h10, 5'h02, 16'h0, rv, ta_ok, end_oe, dwe, dre, doe);
    chk(dre == 1 && re_a == 19'h4, "R13", "page cleared by reset", re_a, 19'h4);
    chk(rv == 16'h0000, "R8", "lower half data", rv, 16'h0000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule